// File: doc/BRIEF.md
# Word-Serial Constant-Secret Response Multiplier-Adder

This block produces the prover response y = r + c × s for a challenge-response identification scheme. It holds three operands in internal storage: the secret s, the commitment r and the challenge c. Any word of these can be written through a narrow write port while the block is idle. After a start pulse the block multiplies and adds using one narrow adder only. The default adder width is 16 bits, and all operands pass through it one adder-width word at a time.

The multiply runs shift-and-add with the most significant challenge bit first. For each challenge bit the accumulator passes once through the adder, word by word. Each word is shifted left by one bit and, if the current challenge bit is set, the matching word of s is added to it. The bit that shifts out of one word and the adder carry are both held in registers for the next word. When all challenge bits are done, the same adder makes one more pass that adds r word by word. A one-cycle done pulse then marks the result as ready. The result stays readable one word at a time through a combinational read port until the next accepted start clears it.

Doubling the adder width halves the number of words per pass and so halves the run time. The cost is a wider adder and a wider data path.

Top module: `shsa_resp_engine`

## Requirements
- R1: After reset, busy_o and done_o are low and every result word reads zero.
- R2: A write with wr_en_i high while the block is idle stores wr_data_i into word wr_addr_i of one operand: wr_sel_i 0 selects the secret, 1 the commitment and 2 the challenge. Word 0 is the least significant word. Select code 3 changes no operand.
- R3: The result equals r + c × s exactly, with SW = 128, CW = 32 and a commitment of SW + CW bits. It spans (SW + CW)/DW + 1 words, word 0 least significant, so the final carry is kept in the top word.
- R4: Start is sampled at a rising edge while the block is idle. done_o is then high in the cycle that follows exactly CW × (SW + CW)/DW + (SW + CW)/DW + 1 further rising edges, which is 331 edges for the defaults.
- R5: done_o stays high for exactly one cycle and is never high while busy_o is high. busy_o is high from the edge that accepts a start until the edge that raises done_o.
- R6: A start pulse that arrives while busy_o is high is ignored: the run in progress keeps its latency and its result.
- R7: Writes that arrive while busy_o is high change no operand. Neither the current result nor any later result reflects them.
- R8: A start pulse in the same cycle as done_o begins a new run. The result of the finished run can still be read during that done cycle.
- R9: The challenge is consumed most significant bit first. A challenge with only its top and bottom bits set gives s × (2^(CW-1) + 1) + r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Operand word write strobe |
| wr_sel_i | input | 2 | Operand select: 0 secret, 1 commitment, 2 challenge |
| wr_addr_i | input | 4 | Word index within the selected operand |
| wr_data_i | input | DW | Operand word to store |
| start_i | input | 1 | Begin a computation when idle |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse: result ready |
| rd_addr_i | input | 4 | Result word index |
| rd_data_o | output | DW | Result word, combinational |

## Verification
Two events can fall in the same cycle: a done pulse and the acceptance of a new start. They collide when the driver holds start_i high during the cycle in which done_o is seen. In that same cycle the monitor reads every result word before the clearing edge. The second run is judged on its full result and on its start-to-done latency. A write that coincides with a running computation is also provoked, together with a stray start in the middle of a run. Both are judged by the result of the current run and of the following run, and by the unchanged latency.

// File: rtl/shsa_pkg.sv
`timescale 1ns/1ps
package shsa_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MUL  = 2'd1,
    PH_ADD  = 2'd2
  } phase_e;

  localparam logic [1:0] SEL_SECRET = 2'd0;
  localparam logic [1:0] SEL_COMMIT = 2'd1;
  localparam logic [1:0] SEL_CHAL   = 2'd2;
endpackage

// File: rtl/shsa_store.sv
`timescale 1ns/1ps
module shsa_store #(
  parameter int DW  = 16,
  parameter int SW  = 128,
  parameter int CW  = 32,
  parameter int RW  = 160,
  parameter int AW  = 4,
  parameter int BW  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] idx_i,
  input  logic [BW-1:0] bit_idx_i,
  output logic [DW-1:0] s_word_o,
  output logic [DW-1:0] r_word_o,
  output logic          ch_bit_o
);
  import shsa_pkg::*;

  localparam int S_WORDS = SW / DW;
  localparam int R_WORDS = RW / DW;
  localparam int C_WORDS = CW / DW;

  logic [SW-1:0] s_q;
  logic [RW-1:0] r_q;
  logic [CW-1:0] c_q;
  logic          wr_ok;

  assign wr_ok = wr_en_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= '0;
      r_q <= '0;
      c_q <= '0;
    end else if (wr_ok) begin
      case (wr_sel_i)
        SEL_SECRET: if (int'(wr_addr_i) < S_WORDS) s_q[int'(wr_addr_i)*DW +: DW] <= wr_data_i;
        SEL_COMMIT: if (int'(wr_addr_i) < R_WORDS) r_q[int'(wr_addr_i)*DW +: DW] <= wr_data_i;
        SEL_CHAL:   if (int'(wr_addr_i) < C_WORDS) c_q[int'(wr_addr_i)*DW +: DW] <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    s_word_o = '0;
    r_word_o = '0;
    if (int'(idx_i) < S_WORDS) s_word_o = s_q[int'(idx_i)*DW +: DW];
    if (int'(idx_i) < R_WORDS) r_word_o = r_q[int'(idx_i)*DW +: DW];
    ch_bit_o = c_q[bit_idx_i];
  end

  AST_WR_BLOCKED_S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(s_q)); // R7
  AST_WR_BLOCKED_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(r_q)); // R7
  AST_WR_BLOCKED_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(c_q)); // R7
endmodule

// File: rtl/shsa_acc.sv
`timescale 1ns/1ps
module shsa_acc #(
  parameter int DW      = 16,
  parameter int Y_WORDS = 11,
  parameter int AW      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] word_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int YB = Y_WORDS * DW;

  logic [YB-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else if (we_i) begin
      for (int k = 0; k < Y_WORDS; k++) begin
        if (int'(idx_i) == k) acc_q[k*DW +: DW] <= wdata_i;
      end
    end
  end

  always_comb begin
    word_o    = '0;
    rd_data_o = '0;
    if (int'(idx_i) < Y_WORDS)     word_o    = acc_q[int'(idx_i)*DW +: DW];
    if (int'(rd_addr_i) < Y_WORDS) rd_data_o = acc_q[int'(rd_addr_i)*DW +: DW];
  end

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0)); // R8
  AST_WIDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (int'(idx_i) < Y_WORDS)); // R3
endmodule

// File: rtl/shsa_slice_add.sv
`timescale 1ns/1ps
module shsa_slice_add #(
  parameter int DW      = 16,
  parameter int P_WORDS = 10,
  parameter int AW      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  shsa_pkg::phase_e phase_i,
  input  logic             first_i,
  input  logic [AW-1:0]    word_idx_i,
  input  logic             ch_bit_i,
  input  logic [DW-1:0]    acc_word_i,
  input  logic [DW-1:0]    s_word_i,
  input  logic [DW-1:0]    r_word_i,
  output logic [DW-1:0]    sum_o
);
  import shsa_pkg::*;

  logic          carry_q, msb_q;
  logic          shift_in, cin, cout;
  logic [DW-1:0] opa, opb;
  logic [DW:0]   wide;

  always_comb begin
    shift_in = (phase_i == PH_MUL) && !first_i && msb_q;
    cin      = !first_i && carry_q;
    if (phase_i == PH_MUL) begin
      opa = {acc_word_i[DW-2:0], shift_in};
      opb = ch_bit_i ? s_word_i : '0;
    end else begin
      opa = acc_word_i;
      opb = r_word_i;
    end
    wide  = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
    sum_o = wide[DW-1:0];
    cout  = wide[DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      msb_q   <= 1'b0;
    end else if (phase_i != PH_IDLE) begin
      carry_q <= cout;
      msb_q   <= acc_word_i[DW-1];
    end
  end

  // the product never spills past the top multiply word
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_MUL && int'(word_idx_i) == P_WORDS-1) |-> (!cout && !acc_word_i[DW-1])); // R3
  AST_ADD_TOP_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_ADD && int'(word_idx_i) == P_WORDS) |-> !cout); // R3
endmodule

// File: rtl/shsa_ctrl.sv
`timescale 1ns/1ps
module shsa_ctrl #(
  parameter int CW      = 32,
  parameter int P_WORDS = 10,
  parameter int Y_WORDS = 11,
  parameter int AW      = 4,
  parameter int BW      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output shsa_pkg::phase_e phase_o,
  output logic [AW-1:0]    word_idx_o,
  output logic [BW-1:0]    bit_idx_o,
  output logic             first_o,
  output logic             clr_o,
  output logic             we_o,
  output logic             busy_o,
  output logic             done_o
);
  import shsa_pkg::*;

  phase_e        phase_q;
  logic [AW-1:0] word_q;
  logic [BW-1:0] bit_q;
  logic          done_q;
  logic          last_word;

  always_comb begin
    if (phase_q == PH_MUL) last_word = (word_q == AW'(P_WORDS-1));
    else                   last_word = (word_q == AW'(Y_WORDS-1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      word_q  <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_MUL;
          word_q  <= '0;
          bit_q   <= BW'(CW-1);
        end
        PH_MUL: if (last_word) begin
          word_q <= '0;
          if (bit_q == '0) phase_q <= PH_ADD;
          else             bit_q   <= bit_q - 1'b1;
        end else begin
          word_q <= word_q + 1'b1;
        end
        PH_ADD: if (last_word) begin
          phase_q <= PH_IDLE;
          word_q  <= '0;
          done_q  <= 1'b1;
        end else begin
          word_q <= word_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign word_idx_o = word_q;
  assign bit_idx_o  = bit_q;
  assign first_o    = (word_q == '0);
  assign clr_o      = (phase_q == PH_IDLE) && start_i;
  assign we_o       = (phase_q != PH_IDLE);
  assign busy_o     = (phase_q != PH_IDLE);
  assign done_o     = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o); // R5
  AST_DONE_AFTER_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(phase_q) == PH_ADD)); // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MUL && start_i) |=> busy_o); // R6
  AST_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (bit_q == BW'(CW-1))); // R9
endmodule

// File: rtl/shsa_resp_engine.sv
`timescale 1ns/1ps
module shsa_resp_engine #(
  parameter int DW = 16,
  parameter int SW = 128,
  parameter int CW = 32,
  localparam int P_WORDS = (SW + CW) / DW,
  localparam int Y_WORDS = P_WORDS + 1,
  localparam int AW      = $clog2(Y_WORDS),
  localparam int BW      = $clog2(CW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  import shsa_pkg::*;

  localparam int RW = P_WORDS * DW;

  phase_e        phase;
  logic [AW-1:0] word_idx;
  logic [BW-1:0] bit_idx;
  logic          first, clr, we, ch_bit;
  logic [DW-1:0] s_word, r_word, acc_word, sum;

  shsa_ctrl #(
    .CW(CW), .P_WORDS(P_WORDS), .Y_WORDS(Y_WORDS), .AW(AW), .BW(BW)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .phase_o    (phase),
    .word_idx_o (word_idx),
    .bit_idx_o  (bit_idx),
    .first_o    (first),
    .clr_o      (clr),
    .we_o       (we),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  shsa_store #(
    .DW(DW), .SW(SW), .CW(CW), .RW(RW), .AW(AW), .BW(BW)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_o),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .idx_i     (word_idx),
    .bit_idx_i (bit_idx),
    .s_word_o  (s_word),
    .r_word_o  (r_word),
    .ch_bit_o  (ch_bit)
  );

  shsa_acc #(
    .DW(DW), .Y_WORDS(Y_WORDS), .AW(AW)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .we_i      (we),
    .idx_i     (word_idx),
    .wdata_i   (sum),
    .word_o    (acc_word),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  shsa_slice_add #(
    .DW(DW), .P_WORDS(P_WORDS), .AW(AW)
  ) u_add (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .first_i    (first),
    .word_idx_i (word_idx),
    .ch_bit_i   (ch_bit),
    .acc_word_i (acc_word),
    .s_word_i   (s_word),
    .r_word_i   (r_word),
    .sum_o      (sum)
  );

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R5
endmodule

// File: tb/sim_shsa_resp_engine.sv
`timescale 1ns/1ps
module sim_shsa_resp_engine;
  localparam int DW = 16, SW = 128, CW = 32;
  localparam int P_WORDS = (SW + CW) / DW;
  localparam int Y_WORDS = P_WORDS + 1;
  localparam int AW = $clog2(Y_WORDS);
  localparam int RW = P_WORDS * DW;
  localparam int YB = Y_WORDS * DW;
  localparam int LAT = CW * P_WORDS + Y_WORDS;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [1:0] wr_sel = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic busy, done;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [YB-1:0] exp_q[$];
  int            stc_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  shsa_resp_engine #(.DW(DW), .SW(SW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .start_i(start),
    .busy_o(busy), .done_o(done), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [YB-1:0] act, input logic [YB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [1:0] sel, input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_addr = AW'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load(input logic [SW-1:0] s, input logic [RW-1:0] r, input logic [CW-1:0] c);
    for (int k = 0; k < SW/DW; k++) wr_word(2'd0, k, s[k*DW +: DW]); // R2 secret
    for (int k = 0; k < RW/DW; k++) wr_word(2'd1, k, r[k*DW +: DW]); // R2 commit
    for (int k = 0; k < CW/DW; k++) wr_word(2'd2, k, c[k*DW +: DW]); // R2 challenge
  endtask

  function automatic logic [YB-1:0] model(input logic [SW-1:0] s, input logic [RW-1:0] r, input logic [CW-1:0] c);
    logic [YB-1:0] se, re, ce;
    se = YB'(s); re = YB'(r); ce = YB'(c);
    return re + ce * se;
  endfunction

  // mode 0 plain, 1 stray start mid-run, 2 stray write mid-run, 3 back-to-back restart
  task automatic run(input logic [YB-1:0] exp, input string tag, input int mode);
    @(negedge clk);
    start = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    start = 0;
    stc_q.push_back(cyc);
    check(busy == 1'b1, "R5 busy after accept", YB'(busy), YB'(1));
    repeat (40) @(negedge clk);
    if (mode == 1) begin start = 1; @(negedge clk); start = 0; end // R6
    if (mode == 2) begin
      wr_en = 1; wr_sel = 2'd0; wr_addr = '0; wr_data = 16'hFFFF; // R7
      @(negedge clk); wr_en = 0;
      wr_en = 1; wr_sel = 2'd2; wr_addr = '0; wr_data = 16'h0000;
      @(negedge clk); wr_en = 0;
    end
    while (!done) @(negedge clk);
    if (mode == 3) begin
      start = 1; // R8 restart in the done cycle
      exp_q.push_back(exp); tag_q.push_back("R8 back-to-back");
      @(negedge clk);
      start = 0;
      stc_q.push_back(cyc);
      while (!done) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done && rst_n) begin
        logic [YB-1:0] got, exp;
        string tag;
        int st;
        for (int k = 0; k < Y_WORDS; k++) begin
          rd_addr = AW'(k);
          #0.2;
          got[k*DW +: DW] = rd_data;
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected done", '0, '0);
        end else begin
          exp = exp_q.pop_front(); tag = tag_q.pop_front(); st = stc_q.pop_front();
          check(got == exp, {tag, " R3 result"}, got, exp);
          check((cyc - st) == LAT, {tag, " R4 latency"}, YB'(cyc - st), YB'(LAT));
        end
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", YB'(done), '0);
      end
    end
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] s;
    logic [RW-1:0] r;
    logic [CW-1:0] c;
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy reset", YB'(busy), '0);
    check(done == 0, "R1 done reset", YB'(done), '0);
    for (int k = 0; k < Y_WORDS; k++) begin
      rd_addr = AW'(k); #0.2;
      check(rd_data == 0, "R1 result zero", YB'(rd_data), '0);
    end
    rst_n = 1;
    @(negedge clk);

    s = SW'(3); r = RW'(5); c = CW'(7);
    load(s, r, c); run(model(s, r, c), "R2 small", 0);

    s = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210; r = {32'h1357_9BDF, 128'h2468_ACE0_1122_3344_5566_7788_99AA_BBCC}; c = '0;
    load(s, r, c); run(model(s, r, c), "R3 zero challenge", 0);

    s = '1; r = '1; c = '1;
    load(s, r, c); run(model(s, r, c), "R3 all ones carry ripple", 0);

    s = 128'hDEAD_BEEF_0000_FFFF_8000_0001_C0DE_F00D; r = RW'(160'h1); c = 32'h8000_0001;
    load(s, r, c); run(model(s, r, c), "R9 msb first", 0);

    c = 32'hA5C3_5A3C;
    wr_word(2'd2, 0, c[15:0]); wr_word(2'd2, 1, c[31:16]);
    run(model(s, r, c), "R6 stray start", 1);

    run(model(s, r, c), "R7 write during busy", 2);
    run(model(s, r, c), "R7 next run unchanged", 0);

    wr_word(2'd3, 0, 16'h7777); // R2 code 3 no effect
    run(model(s, r, c), "R2 select 3 ignored", 3);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R5 all results seen", YB'(exp_q.size()), '0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule